// File: doc/BRIEF.md
# PC/AT-Style Bus Target Cycle Decoder

This block answers bus cycles on a 16-bit PC/AT-style expansion bus as a target and turns each accepted cycle into one request on a simple internal port. That port uses a request/acknowledge/error handshake. The bus offers two cycle families.

Normal cycles use the ordinary read and write strobes. They count only when a chip-select is low: one chip-select for the block's own registers and one for system memory. Extended cycles use a separate pair of strobes and carry a 32-bit address. The top three bits of that address arrive on pins that the bus shares with other functions, and the next five bits arrive on a small extra input. Extended cycles take no notice of either chip-select and always go to memory.

While the internal side is still working, the block holds the active-low ready line low to stretch the bus cycle. When the answer arrives, the block releases ready. For a read, it presents the returned data until the master takes its strobe away. If the internal side reports an error, the block asserts the active-low fault line.

Top module: `isaSlaveDecoder`

## Requirements
- R1: A normal write strobe (`wrN` low) or normal read strobe (`rdN` low) starts a cycle only while `regCsN` or `memCsN` is low. With both chip-selects high the strobe is ignored: `reqValid` stays 0 and `readyN` stays 1.
- R2: `reqReg` is 1 for a normal cycle with `regCsN` low. This holds even if `memCsN` is also low. `reqReg` is 0 for a normal cycle selected only by `memCsN`, and 0 for every extended cycle.
- R3: Extended strobes (`wrExtN`, `rdExtN`) start a cycle whatever the chip-selects are. The address of an extended cycle is {`addrTop`[2:0] as bits 31..29, `addrExt`[4:0] as bits 28..24, `addr`[23:0] as bits 23..0}. A normal cycle's address is `addr` with bits 31..24 set to zero.
- R4: When several qualified strobes are low at once, the cycle kind follows this priority, highest first: extended write, extended read, normal write, normal read. `reqWrite` is 1 for the two write kinds.
- R5: `readyN` goes low in the cycle after a qualified strobe is sampled. It stays low, with `reqValid` high, up to and including the clock edge at which `ackIn` is sampled high. It is 1 at all other times.
- R6: `reqAddr`, `reqWdata` and the cycle kind are captured at the clock edge where the cycle is accepted. Later changes on `addr`, `dataIn` or the chip-selects do not alter them.
- R7: For a read, the `rdataIn` value sampled together with `ackIn` appears on `dataOut` with `dataOe` = 1. It stays there until all four strobes are high. For writes, `dataOe` stays 0.
- R8: If `errIn` is high when `ackIn` is sampled, `faultN` is 0 from the next cycle until all four strobes are high. Otherwise `faultN` is 1.
- R9: `reqByteEn` is 2'b11 when `bheN` is low at acceptance and 2'b01 when it is high. Bit 0 stands for the low byte.
- R10: After a cycle completes, no new cycle is accepted until all four strobes have been sampled high.
- R11: `busReset` (synchronous, active high) returns the block to idle: `readyN`=1, `reqValid`=0, `dataOe`=0 and `faultN`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| busReset | input | 1 | Synchronous bus reset, active high |
| wrN | input | 1 | Normal write strobe, active low |
| rdN | input | 1 | Normal read strobe, active low |
| wrExtN | input | 1 | Extended write strobe, active low |
| rdExtN | input | 1 | Extended read strobe, active low |
| regCsN | input | 1 | Register chip-select, active low |
| memCsN | input | 1 | Memory chip-select, active low |
| bheN | input | 1 | Upper byte enable, active low |
| addrTop | input | 3 | Address bits 31..29 for extended cycles |
| addrExt | input | 5 | Address bits 28..24 for extended cycles |
| addr | input | 24 | Bus address bits 23..0 |
| dataIn | input | 16 | Write data from the bus |
| dataOut | output | 16 | Read data toward the bus |
| dataOe | output | 1 | Enable for driving `dataOut` |
| readyN | output | 1 | Cycle stretch, active low |
| faultN | output | 1 | Error indication, active low |
| reqValid | output | 1 | Internal request pending |
| reqWrite | output | 1 | Request is a write |
| reqReg | output | 1 | Request targets block registers |
| reqAddr | output | 32 | Request address |
| reqWdata | output | 16 | Request write data |
| reqByteEn | output | 2 | Request byte mask |
| ackIn | input | 1 | Internal side completes the request |
| errIn | input | 1 | Internal side reports failure, valid with `ackIn` |
| rdataIn | input | 16 | Read data from the internal side, valid with `ackIn` |

## Verification
Two functions can coincide in one clock edge. The first is strobe arbitration, where two or more strobes are low together. The second is the re-acceptance guard, where a strobe is still low just as the previous cycle ends. The bench provokes both in these ways:
- It drives an extended write together with a normal read, and a normal write together with a normal read.
- It holds a strobe low for several cycles after the acknowledge.

The behavioural model compares every clock. It must show that exactly one request of the expected kind is raised, and that no second request begins before all strobes have been sampled high.

// File: rtl/slvPkg.sv
package slvPkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_HOLD = 2'd2
  } slvState_t;

  // candidate cycle seen on the bus this clock
  typedef struct packed {
    logic valid;
    logic write;
    logic ext;
  } slvCand_t;

  // strobes from control to datapath
  typedef struct packed {
    logic captureReq;
    logic captureRsp;
  } slvStrb_t;
endpackage

// File: rtl/slvDatapath.sv
module slvDatapath
  import slvPkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int TOP_W  = 3,
  parameter int EXT_W  = 5,
  localparam int SYS_AW = TOP_W + EXT_W + ADDR_W,
  localparam int BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              busReset,
  input  logic              wrN,
  input  logic              rdN,
  input  logic              wrExtN,
  input  logic              rdExtN,
  input  logic              regCsN,
  input  logic              memCsN,
  input  logic              bheN,
  input  logic [TOP_W-1:0]  addrTop,
  input  logic [EXT_W-1:0]  addrExt,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              errIn,
  input  logic [DATA_W-1:0] rdataIn,
  input  slvStrb_t          strb,
  output slvCand_t          cand,
  output logic              strobesIdle,
  output logic              reqWrite,
  output logic              reqReg,
  output logic [SYS_AW-1:0] reqAddr,
  output logic [DATA_W-1:0] reqWdata,
  output logic [BE_W-1:0]   reqByteEn,
  output logic              latErr,
  output logic [DATA_W-1:0] latRdata
);
  localparam int HI_W = SYS_AW - ADDR_W;
  localparam int HALF = (BE_W + 1) / 2;

  logic csAny;
  logic [SYS_AW-1:0] nextAddr;
  logic [BE_W-1:0] nextBe;

  assign csAny = !regCsN || !memCsN;
  assign strobesIdle = wrN && rdN && wrExtN && rdExtN;

  // priority decode of the active strobes
  always_comb begin
    cand = '0;
    if (!wrExtN) begin
      cand.valid = 1'b1; cand.write = 1'b1; cand.ext = 1'b1;
    end else if (!rdExtN) begin
      cand.valid = 1'b1; cand.write = 1'b0; cand.ext = 1'b1;
    end else if (!wrN && csAny) begin
      cand.valid = 1'b1; cand.write = 1'b1; cand.ext = 1'b0;
    end else if (!rdN && csAny) begin
      cand.valid = 1'b1; cand.write = 1'b0; cand.ext = 1'b0;
    end
  end

  assign nextAddr = cand.ext ? {addrTop, addrExt, addr}
                             : {{HI_W{1'b0}}, addr};

  // low half of the lanes always, upper half only with byte-high enable
  generate
    for (genvar g = 0; g < BE_W; g++) begin : gLane
      if (g < HALF) begin : gLow
        assign nextBe[g] = 1'b1;
      end else begin : gHigh
        assign nextBe[g] = !bheN;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (busReset) begin
      reqWrite  <= 1'b0;
      reqReg    <= 1'b0;
      reqAddr   <= '0;
      reqWdata  <= '0;
      reqByteEn <= '0;
      latErr    <= 1'b0;
      latRdata  <= '0;
    end else begin
      if (strb.captureReq) begin
        reqWrite  <= cand.write;
        reqReg    <= !cand.ext && !regCsN;
        reqAddr   <= nextAddr;
        reqWdata  <= dataIn;
        reqByteEn <= nextBe;
        latErr    <= 1'b0;
      end
      if (strb.captureRsp) begin
        latRdata <= rdataIn;
        latErr   <= errIn;
      end
    end
  end
endmodule

// File: rtl/slvCtrl.sv
module slvCtrl
  import slvPkg::*;
(
  input  logic     clk,
  input  logic     busReset,
  input  slvCand_t cand,
  input  logic     strobesIdle,
  input  logic     ackIn,
  input  logic     reqWrite,
  input  logic     latErr,
  output slvStrb_t strb,
  output logic     reqValid,
  output logic     readyN,
  output logic     dataOe,
  output logic     faultN
);
  slvState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strb = '0;
    unique case (state)
      ST_IDLE: if (cand.valid) begin
        stateNext = ST_REQ;
        strb.captureReq = 1'b1;
      end
      ST_REQ: if (ackIn) begin
        stateNext = ST_HOLD;
        strb.captureRsp = 1'b1;
      end
      ST_HOLD: if (strobesIdle) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (busReset) state <= ST_IDLE;
    else          state <= stateNext;
  end

  assign reqValid = (state == ST_REQ);
  assign readyN   = (state != ST_REQ);
  assign dataOe   = (state == ST_HOLD) && !reqWrite;
  assign faultN   = !((state == ST_HOLD) && latErr);
endmodule

// File: rtl/isaSlaveDecoder.sv
module isaSlaveDecoder
  import slvPkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int TOP_W  = 3,
  parameter int EXT_W  = 5,
  localparam int SYS_AW = TOP_W + EXT_W + ADDR_W,
  localparam int BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              busReset,
  input  logic              wrN,
  input  logic              rdN,
  input  logic              wrExtN,
  input  logic              rdExtN,
  input  logic              regCsN,
  input  logic              memCsN,
  input  logic              bheN,
  input  logic [TOP_W-1:0]  addrTop,
  input  logic [EXT_W-1:0]  addrExt,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              readyN,
  output logic              faultN,
  output logic              reqValid,
  output logic              reqWrite,
  output logic              reqReg,
  output logic [SYS_AW-1:0] reqAddr,
  output logic [DATA_W-1:0] reqWdata,
  output logic [BE_W-1:0]   reqByteEn,
  input  logic              ackIn,
  input  logic              errIn,
  input  logic [DATA_W-1:0] rdataIn
);
  slvCand_t cand;
  slvStrb_t strb;
  logic strobesIdle;
  logic latErr;

  slvDatapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TOP_W(TOP_W), .EXT_W(EXT_W)
  ) uDp (
    .clk(clk), .busReset(busReset),
    .wrN(wrN), .rdN(rdN), .wrExtN(wrExtN), .rdExtN(rdExtN),
    .regCsN(regCsN), .memCsN(memCsN), .bheN(bheN),
    .addrTop(addrTop), .addrExt(addrExt), .addr(addr), .dataIn(dataIn),
    .errIn(errIn), .rdataIn(rdataIn), .strb(strb),
    .cand(cand), .strobesIdle(strobesIdle),
    .reqWrite(reqWrite), .reqReg(reqReg), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqByteEn(reqByteEn),
    .latErr(latErr), .latRdata(dataOut)
  );

  slvCtrl uCtrl (
    .clk(clk), .busReset(busReset),
    .cand(cand), .strobesIdle(strobesIdle), .ackIn(ackIn),
    .reqWrite(reqWrite), .latErr(latErr),
    .strb(strb), .reqValid(reqValid), .readyN(readyN),
    .dataOe(dataOe), .faultN(faultN)
  );
endmodule

// File: rtl/isaSlaveDecoder_chk.sv
module isaSlaveDecoder_chk #(
  parameter int AW = 32,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          busReset,
  input logic          wrN,
  input logic          rdN,
  input logic          wrExtN,
  input logic          rdExtN,
  input logic          ackIn,
  input logic          errIn,
  input logic          reqValid,
  input logic          readyN,
  input logic          dataOe,
  input logic          faultN,
  input logic [AW-1:0] reqAddr,
  input logic [DW-1:0] reqWdata
);
  a_r1_start_needs_strobe: assert property (@(posedge clk) disable iff (busReset)
    $rose(reqValid) |-> $past(!(wrN && rdN && wrExtN && rdExtN)));

  a_r5_ack_releases_ready: assert property (@(posedge clk) disable iff (busReset)
    (reqValid && ackIn) |=> (readyN && !reqValid));

  a_r6_request_stable: assert property (@(posedge clk) disable iff (busReset)
    (reqValid && $past(reqValid)) |-> ($stable(reqAddr) && $stable(reqWdata)));

  a_r7_data_held: assert property (@(posedge clk) disable iff (busReset)
    (dataOe && !(wrN && rdN && wrExtN && rdExtN)) |=> dataOe);

  a_r8_fault_cause: assert property (@(posedge clk) disable iff (busReset)
    $fell(faultN) |-> $past(ackIn && errIn));

  a_r11_reset_idle: assert property (@(posedge clk)
    busReset |=> (readyN && !reqValid && !dataOe && faultN));
endmodule

bind isaSlaveDecoder isaSlaveDecoder_chk #(
  .AW(TOP_W + EXT_W + ADDR_W), .DW(DATA_W)
) uChk (
  .clk(clk), .busReset(busReset),
  .wrN(wrN), .rdN(rdN), .wrExtN(wrExtN), .rdExtN(rdExtN),
  .ackIn(ackIn), .errIn(errIn),
  .reqValid(reqValid), .readyN(readyN), .dataOe(dataOe), .faultN(faultN),
  .reqAddr(reqAddr), .reqWdata(reqWdata)
);

// File: tb/isaSlaveDecoder_test.sv
module isaSlaveDecoder_test;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic busReset = 1'b1;
  logic wrN = 1, rdN = 1, wrExtN = 1, rdExtN = 1;
  logic regCsN = 1, memCsN = 1, bheN = 1;
  logic [2:0] addrTop = '0;
  logic [4:0] addrExt = '0;
  logic [23:0] addr = '0;
  logic [15:0] dataIn = '0;
  logic ackIn = 0, errIn = 0;
  logic [15:0] rdataIn = '0;
  logic [15:0] dataOut;
  logic dataOe, readyN, faultN, reqValid, reqWrite, reqReg;
  logic [31:0] reqAddr;
  logic [15:0] reqWdata;
  logic [1:0] reqByteEn;

  int nChecks = 0;
  int nErr = 0;

  always #(PERIOD/2) clk = ~clk;

  isaSlaveDecoder uut (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s act=%h exp=%h @%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int mSt = 0;               // 0 idle, 1 waiting on internal side, 2 answered
  logic [31:0] mAddr = '0;
  logic [15:0] mWd = '0, mRd = '0;
  logic mWr = 0, mReg = 0, mErr = 0;
  logic [1:0] mBe = '0;

  always @(posedge clk) begin
    if (busReset) begin
      mSt <= 0; mErr <= 0;
    end else if (mSt == 0) begin
      bit go; bit w; bit x;
      go = 1; w = 0; x = 0;
      if (!wrExtN) begin w = 1; x = 1; end
      else if (!rdExtN) x = 1;
      else if (!wrN && (!regCsN || !memCsN)) w = 1;
      else if (!rdN && (!regCsN || !memCsN)) w = 0;
      else go = 0;
      if (go) begin
        mSt <= 1; mWr <= w; mErr <= 0;
        mReg <= !x && !regCsN;
        mAddr <= x ? {addrTop, addrExt, addr} : {8'h00, addr};
        mWd <= dataIn;
        mBe <= bheN ? 2'b01 : 2'b11;
      end
    end else if (mSt == 1) begin
      if (ackIn) begin mSt <= 2; mRd <= rdataIn; mErr <= errIn; end
    end else begin
      if (wrN && rdN && wrExtN && rdExtN) mSt <= 0;
    end
  end

  always @(negedge clk) begin
    check(readyN === (mSt != 1), "R5 readyN", {31'b0, readyN}, {31'b0, mSt != 1});
    check(reqValid === (mSt == 1), "R1/R10 reqValid", {31'b0, reqValid}, {31'b0, mSt == 1});
    check(dataOe === (mSt == 2 && !mWr), "R7 dataOe", {31'b0, dataOe}, {31'b0, mSt == 2 && !mWr});
    check(faultN === !(mSt == 2 && mErr), "R8 faultN", {31'b0, faultN}, {31'b0, !(mSt == 2 && mErr)});
    if (mSt == 1) begin
      check(reqAddr === mAddr, "R3 reqAddr", reqAddr, mAddr);
      check(reqReg === mReg, "R2 reqReg", {31'b0, reqReg}, {31'b0, mReg});
      check(reqWrite === mWr, "R4 reqWrite", {31'b0, reqWrite}, {31'b0, mWr});
      check(reqByteEn === mBe, "R9 reqByteEn", {30'b0, reqByteEn}, {30'b0, mBe});
      if (mWr) check(reqWdata === mWd, "R6 reqWdata", {16'b0, reqWdata}, {16'b0, mWd});
    end
    if (mSt == 2 && !mWr)
      check(dataOut === mRd, "R7 dataOut", {16'b0, dataOut}, {16'b0, mRd});
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
    end
  endtask

  task automatic releaseAll();
    wrN = 1; rdN = 1; wrExtN = 1; rdExtN = 1;
  endtask

  // xw, xr, nw, nr: strobes to assert; rc, mc: chip-selects to assert
  task automatic runCycle(input bit xw, input bit xr, input bit nw, input bit nr,
                          input bit rc, input bit mc, input bit bh,
                          input logic [2:0] t, input logic [4:0] e,
                          input logic [23:0] a, input logic [15:0] d,
                          input int lat, input bit er, input logic [15:0] rd,
                          input int extraHold, input bit expectStart);
    bit seen;
    seen = 0;
    regCsN = !rc; memCsN = !mc; bheN = bh;
    addrTop = t; addrExt = e; addr = a; dataIn = d;
    wrExtN = !xw; rdExtN = !xr; wrN = !nw; rdN = !nr;
    if (!expectStart) begin
      tick(5);
      check(!reqValid && readyN, "R1 unselected strobe ignored",
            {30'b0, reqValid, readyN}, 32'h1);
      releaseAll(); tick(2);
      return;
    end
    for (int i = 0; i < 5 && !seen; i++) begin
      tick(1);
      if (reqValid) seen = 1;
    end
    check(seen, "R1 cycle start", {31'b0, seen}, 32'h1);
    // R6: disturb inputs after acceptance
    addr = ~a; dataIn = ~d; regCsN = 1; memCsN = 1; addrTop = ~t;
    tick(lat);
    ackIn = 1; errIn = er; rdataIn = rd;
    tick(1);
    ackIn = 0; errIn = 0; rdataIn = 16'hDEAD;
    check(readyN === 1'b1, "R5 ready released after ack", {31'b0, readyN}, 32'h1);
    for (int i = 0; i < extraHold; i++) begin
      tick(1);
      check(reqValid === 1'b0, "R10 no restart while strobe held", {31'b0, reqValid}, 32'h0);
    end
    releaseAll();
    tick(2);
  endtask

  initial begin
    tick(3);
    check(readyN && !reqValid && !dataOe && faultN, "R11 reset state",
          {28'b0, readyN, reqValid, dataOe, faultN}, 32'h9);
    busReset = 0;
    tick(1);
    // normal write to memory, both bytes
    runCycle(0,0,1,0, 0,1, 0, 3'h0, 5'h00, 24'h12_3456, 16'hBEEF, 2, 0, 16'h0, 0, 1);
    // normal read from registers, low byte only
    runCycle(0,0,0,1, 1,0, 1, 3'h0, 5'h00, 24'h00_0042, 16'h0, 0, 0, 16'hA5C3, 0, 1);
    // unselected strobes ignored
    runCycle(0,0,1,0, 0,0, 0, 3'h0, 5'h00, 24'h00_0010, 16'h1111, 0, 0, 16'h0, 0, 0);
    runCycle(0,0,0,1, 0,0, 1, 3'h0, 5'h00, 24'h00_0020, 16'h0, 0, 0, 16'h0, 0, 0);
    // extended read, no chip-select, with error
    runCycle(0,1,0,0, 0,0, 0, 3'b101, 5'h13, 24'hFE_DCBA, 16'h0, 3, 1, 16'h7777, 0, 1);
    // extended write with register select low: still memory
    runCycle(1,0,0,0, 1,0, 1, 3'b011, 5'h0A, 24'h00_ABCD, 16'h5A5A, 1, 0, 16'h0, 0, 1);
    // priority: extended write over normal read
    runCycle(1,0,0,1, 0,1, 0, 3'b110, 5'h1F, 24'h11_1111, 16'h2222, 0, 0, 16'h0, 0, 1);
    // priority: normal write over normal read, both chip-selects low
    runCycle(0,0,1,1, 1,1, 0, 3'h0, 5'h00, 24'h33_4444, 16'h6789, 1, 0, 16'h0, 0, 1);
    // strobe kept low after completion, then a fresh cycle
    runCycle(0,0,0,1, 0,1, 0, 3'h0, 5'h00, 24'h00_8000, 16'h0, 0, 0, 16'h0F0F, 4, 1);
    runCycle(0,0,0,1, 0,1, 0, 3'h0, 5'h00, 24'h00_8002, 16'h0, 0, 1, 16'hF0F0, 3, 1);
    // extended read preferred over normal write
    runCycle(0,1,1,0, 0,1, 1, 3'b001, 5'h01, 24'h00_0001, 16'h9999, 2, 0, 16'h1234, 0, 1);
    // reset in the middle of a cycle
    memCsN = 0; wrN = 0; addr = 24'h55_5555;
    tick(2);
    check(reqValid === 1'b1, "R1 start before reset", {31'b0, reqValid}, 32'h1);
    busReset = 1;
    tick(1);
    busReset = 0; releaseAll();
    check(readyN && !reqValid && !dataOe && faultN, "R11 reset mid cycle",
          {28'b0, readyN, reqValid, dataOe, faultN}, 32'h9);
    tick(3);
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    nErr++; nChecks++;
    $display("FAIL R11 watchdog act=hung exp=finished");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule